// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an asynchronous static RAM with a 16-bit data path. The host hands over one command at a time through a valid/ready handshake. Each command carries an address, a write flag, write data and a two-bit byte mask. The controller then produces the chip-enable, write-enable, output-enable and byte-lane pin sequence for one memory cycle. Every phase of that sequence is long enough for the memory's access, pulse-width, setup and bus-float limits.

Phase lengths are computed when the design is elaborated. Each limit in picoseconds is divided by the clock period and rounded up, with a floor of one clock. The `SLOW_GRADE` parameter selects the timing set for the slower memory grade. The data bus is split into an outgoing word, an incoming word and a drive enable, so the pad ring owns the tristate buffer.

A read keeps the memory selected with output enable low for a full cycle time. It captures the data bus on the last clock of that cycle and returns the word with a single-cycle valid pulse. A write holds output enable high throughout. It waits until any drivers left on from a preceding read have floated, and only then starts the write pulse.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and directly after reset, `req_ready` is 1, `rd_valid` is 0, `sram_dq_oe` is 0, and the pins are idle: `sram_ce1_n`, `sram_we_n`, `sram_oe_n`, `sram_lb_n` and `sram_ub_n` are all 1, and `sram_ce2` is 0.
- R2: A command is taken on a clock where `req_valid` and `req_ready` are both 1. From the next cycle on, `req_ready` stays 0 until that access has finished.
- R3: A read keeps the chip selected (`sram_ce1_n`=0, `sram_ce2`=1) with `sram_oe_n`=0 and `sram_we_n`=1 for exactly READ_CLKS clocks, which is 18 at the defaults (ceil(70 ns / 4 ns)). `sram_dq_in` is captured on the last of those clocks. `rd_valid` then pulses high for one cycle with the captured word. A write never raises `rd_valid`.
- R4: Mask bit 0 enables the lower lane (bits 7:0, `sram_lb_n` low). Mask bit 1 enables the upper lane (bits 15:8, `sram_ub_n` low). A disabled lane reads back as zero and its stored byte is left unchanged by a write.
- R5: A write holds `sram_we_n` low for exactly WE_CLKS clocks. WE_CLKS is the larger of the rounded-up write-pulse minimum and data-setup minimum, which gives 9 at the defaults. `sram_oe_n` is 1 whenever `sram_we_n` is 0.
- R6: `sram_dq_oe` rises on the clock where `sram_we_n` falls. It stays high, with `sram_dq_out` equal to the command's write data, until the chip is deselected. It is never high while the chip is deselected or `sram_oe_n` is 0.
- R7: A write keeps the chip selected for at least the cycle time in clocks (18 at the defaults).
- R8: `sram_addr` changes only while `sram_we_n` is 1, both before and after the change.
- R9: After `sram_oe_n` rises, `sram_dq_oe` does not rise until more than FLT_CLKS clocks have passed. FLT_CLKS is the rounded-up bus float time, which is 8 at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host command present |
| req_ready | output | 1 | Controller idle and able to take a command |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce1_n | output | 1 | Chip enable, active low |
| sram_ce2 | output | 1 | Chip enable, active high |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower byte lane enable, active low |
| sram_ub_n | output | 1 | Upper byte lane enable, active low |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | 16 | Data bus as seen from the memory side |

## Verification
The properties assume that `rst` is synchronous and that the host holds a command stable while `req_valid` is high and not yet accepted. They also assume `sram_dq_in` matters only in the last clock of a read. The bench changes host inputs only on falling edges and keeps `req_valid` high for exactly one accepting clock. Its memory model drives a valid word only after the address has been stable with output enable low for the full access time; before that it drives a poison value, so a read captured too early is visible in the returned data.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int ADDR_W     = 17,
  parameter int CLK_PS     = 4000,
  parameter bit SLOW_GRADE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [15:0]       sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [15:0]       sram_dq_in
);

  function automatic int clks(input int t_ps);
    int n;
    n = (t_ps + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_CYC_PS   = SLOW_GRADE ? 100000 : 70000;
  localparam int T_OEACC_PS = SLOW_GRADE ? 50000  : 35000;
  localparam int T_WP_PS    = SLOW_GRADE ? 50000  : 35000;
  localparam int T_DS_PS    = SLOW_GRADE ? 40000  : 30000;
  localparam int T_OEFLT_PS = SLOW_GRADE ? 35000  : 30000;
  localparam int T_WEFLT_PS = SLOW_GRADE ? 40000  : 30000;

  localparam int CYC_CLKS  = clks(T_CYC_PS);
  localparam int READ_CLKS = imax(CYC_CLKS, clks(T_OEACC_PS));
  localparam int WE_CLKS   = imax(clks(T_WP_PS), clks(T_DS_PS));
  localparam int TAIL_CLKS = imax(1, CYC_CLKS - 1 - WE_CLKS);
  localparam int FLT_CLKS  = imax(clks(T_OEFLT_PS), clks(T_WEFLT_PS));
  localparam int CNT_MAX   = imax(READ_CLKS, imax(WE_CLKS, TAIL_CLKS));
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int FLT_W     = $clog2(FLT_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WTURN, S_WLOW, S_WTAIL} state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [FLT_W-1:0]  flt;
  logic              sel;
  logic [1:0]        lane;
  logic              we_n_q, oe_n_q, doe_q, rdv_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       dout_q, rdd_q;
  logic [15:0]       lane_mask;

  assign lane_mask   = {{8{lane[1]}}, {8{lane[0]}}};
  assign req_ready   = (st == S_IDLE);
  assign rd_valid    = rdv_q;
  assign rd_data     = rdd_q;
  assign sram_addr   = addr_q;
  assign sram_ce1_n  = ~sel;
  assign sram_ce2    = sel;
  assign sram_we_n   = we_n_q;
  assign sram_oe_n   = oe_n_q;
  assign sram_lb_n   = ~lane[0];
  assign sram_ub_n   = ~lane[1];
  assign sram_dq_out = dout_q;
  assign sram_dq_oe  = doe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      flt    <= '0;
      sel    <= 1'b0;
      lane   <= 2'b00;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      doe_q  <= 1'b0;
      rdv_q  <= 1'b0;
      addr_q <= '0;
      dout_q <= '0;
      rdd_q  <= '0;
    end else begin
      rdv_q <= 1'b0;
      if (flt != '0) flt <= flt - 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          lane   <= req_be;
          sel    <= 1'b1;
          dout_q <= req_wdata;
          if (req_write) begin
            st <= S_WTURN;
          end else begin
            oe_n_q <= 1'b0;
            cnt    <= CNT_W'(READ_CLKS - 1);
            st     <= S_READ;
          end
        end
        S_READ: if (cnt == '0) begin
          rdd_q  <= sram_dq_in & lane_mask;
          rdv_q  <= 1'b1;
          oe_n_q <= 1'b1;
          sel    <= 1'b0;
          lane   <= 2'b00;
          flt    <= FLT_W'(FLT_CLKS);
          st     <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WTURN: if (flt == '0) begin
          we_n_q <= 1'b0;
          doe_q  <= 1'b1;
          cnt    <= CNT_W'(WE_CLKS - 1);
          st     <= S_WLOW;
        end
        S_WLOW: if (cnt == '0) begin
          we_n_q <= 1'b1;
          cnt    <= CNT_W'(TAIL_CLKS - 1);
          st     <= S_WTAIL;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WTAIL: if (cnt == '0) begin
          doe_q <= 1'b0;
          sel   <= 1'b0;
          lane  <= 2'b00;
          st    <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce1_n,
  input logic              sram_ce2,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe,
  input logic [15:0]       we_clks,
  input logic [15:0]       flt_clks
);

  logic [15:0] we_lo;
  logic [15:0] oe_hi;

  always_ff @(posedge clk) begin
    if (rst || sram_we_n) we_lo <= '0;
    else                  we_lo <= we_lo + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)                    oe_hi <= 16'hFFFF;
    else if (!sram_oe_n)        oe_hi <= '0;
    else if (oe_hi != 16'hFFFF) oe_hi <= oe_hi + 16'd1;
  end

  a_r8_addr_we_high: assert property (@(posedge clk) disable iff (rst)
    !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n)));

  a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_oe_n);

  a_r5_we_width: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_lo == we_clks));

  a_r6_drive_selected: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_ce1_n && sram_ce2 && sram_oe_n));

  a_r3_rdv_single: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r9_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (oe_hi > flt_clks));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .sram_addr  (sram_addr),
  .sram_ce1_n (sram_ce1_n),
  .sram_ce2   (sram_ce2),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe),
  .we_clks    (16'(WE_CLKS)),
  .flt_clks   (16'(FLT_CLKS))
);

// File: tb/tb_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_sram_cycle_ctrl;

  localparam int AW      = 17;
  localparam int CYC_CLK = 18;
  localparam int WE_CLK  = 9;
  localparam int FLT_CLK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = 2'b00;
  logic          req_ready, rd_valid;
  logic [15:0]   rd_data;
  logic [AW-1:0] sram_addr;
  logic          sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe;
  logic [15:0]   sram_dq_out;
  logic [15:0]   mdl_q = 16'hDEAD;

  sram_cycle_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(mdl_q)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int a);
    return 16'(a * 40503) ^ 16'hA5C3;
  endfunction

  logic [15:0] mdl [int];
  logic [15:0] ref_mem [int];

  function automatic logic [15:0] mdl_rd(input int a);
    return mdl.exists(a) ? mdl[a] : init_word(a);
  endfunction

  function automatic logic [15:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
  endfunction

  // memory model: valid data only after a full access time with output enable low
  int            stab = 0;
  logic          prev_rd = 1'b0;
  logic [AW-1:0] prev_a = '0;
  always @(negedge clk) begin
    automatic logic sel   = !sram_ce1_n && sram_ce2;
    automatic logic rd_on = sel && !sram_oe_n && sram_we_n;
    automatic logic [15:0] w;
    if (rd_on && prev_rd && sram_addr == prev_a) stab++;
    else stab = 0;
    prev_rd = rd_on;
    prev_a  = sram_addr;
    if (sel && !sram_we_n && sram_dq_oe) begin
      w = mdl_rd(int'(sram_addr));
      if (!sram_lb_n) w[7:0]  = sram_dq_out[7:0];
      if (!sram_ub_n) w[15:8] = sram_dq_out[15:8];
      mdl[int'(sram_addr)] = w;
    end
    if (rd_on && stab >= CYC_CLK - 1) begin
      w = mdl_rd(int'(sram_addr));
      mdl_q <= {sram_ub_n ? 8'hEE : w[15:8], sram_lb_n ? 8'hEE : w[7:0]};
    end else begin
      mdl_q <= 16'hDEAD;
    end
  end

  logic [15:0] exp_q[$];
  logic        cur_wr = 1'b0;
  logic [1:0]  cur_be = 2'b00;
  logic [15:0] cur_d = '0;

  task automatic do_op(input bit wr, input int a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] w;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
    cur_wr = wr; cur_be = be; cur_d = d;
    w = ref_rd(a);
    if (wr) begin
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      ref_mem[a] = w;
    end else begin
      exp_q.push_back(w & {{8{be[1]}}, {8{be[0]}}});
    end
    @(negedge clk);
    chk(!req_ready, "R2", "ready after accept", 32'(req_ready), 0);
    req_valid = 1'b0;
  endtask

  // pin-level monitor
  logic          p_sel = 1'b0, p_we = 1'b1, p_doe = 1'b0, p_rdv = 1'b0;
  logic [AW-1:0] p_addr = '0;
  int            ce_len = 0, we_len = 0, oe_gap = 1000;
  logic          s_wr;
  logic [1:0]    s_be;
  logic [15:0]   s_d;
  always @(negedge clk) begin
    if (!rst) begin
      automatic logic sel = !sram_ce1_n && sram_ce2;
      automatic logic [15:0] e;
      if (sel && !p_sel) begin
        s_wr = cur_wr; s_be = cur_be; s_d = cur_d; ce_len = 0;
        chk({!sram_ub_n, !sram_lb_n} == s_be, "R4", "lane pins", 32'({!sram_ub_n, !sram_lb_n}), 32'(s_be));
      end
      if (sel) ce_len++;
      if (!sel && p_sel) begin
        if (s_wr) chk(ce_len >= CYC_CLK, "R7", "write select length", ce_len, CYC_CLK);
        else      chk(ce_len == CYC_CLK, "R3", "read select length", ce_len, CYC_CLK);
      end
      if (!sram_we_n) we_len++;
      if (!sram_we_n && !sram_oe_n) chk(1'b0, "R5", "oe low during write", 0, 1);
      if (sram_we_n && !p_we) begin
        chk(we_len == WE_CLK, "R5", "write pulse length", we_len, WE_CLK);
        chk(sram_dq_oe && sram_dq_out == s_d, "R6", "write data on bus", 32'(sram_dq_out), 32'(s_d));
        we_len = 0;
      end
      if (sram_addr != p_addr && (!sram_we_n || !p_we))
        chk(1'b0, "R8", "address moved with we low", 32'(sram_addr), 32'(p_addr));
      if (!sram_oe_n) oe_gap = 0;
      else if (oe_gap < 1000) oe_gap++;
      if (sram_dq_oe && !p_doe) chk(oe_gap > FLT_CLK, "R9", "turnaround gap", oe_gap, FLT_CLK + 1);
      if (sram_dq_oe && !sel) chk(1'b0, "R6", "drive while deselected", 1, 0);
      if (rd_valid && p_rdv) chk(1'b0, "R3", "rd_valid wider than one cycle", 1, 0);
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected rd_valid", 32'(rd_data), 0);
        end else begin
          e = exp_q.pop_front();
          chk(rd_data == e, "R3/R4", "read data", 32'(rd_data), 32'(e));
        end
      end
      p_sel = sel; p_we = sram_we_n; p_doe = sram_dq_oe; p_rdv = rd_valid; p_addr = sram_addr;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(req_ready && !rd_valid && !sram_dq_oe, "R1", "handshake in reset", {rd_valid, sram_dq_oe, req_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    chk({sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n} == 6'b101111,
        "R1", "idle pins", {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n}, 6'b101111);
    chk(req_ready && !rd_valid && !sram_dq_oe, "R1", "idle handshake", {rd_valid, sram_dq_oe, req_ready}, 1);

    do_op(0, 16, 0, 2'b11);          // R3 unwritten word
    do_op(1, 16, 16'h1234, 2'b11);   // R9 write straight after a read
    do_op(0, 16, 0, 2'b11);
    do_op(1, 16, 16'hABCD, 2'b01);   // R4 lower lane only
    do_op(0, 16, 0, 2'b11);
    do_op(0, 16, 0, 2'b10);          // R4 lower lane reads zero
    do_op(0, 16, 0, 2'b01);
    do_op(1, 16, 16'h5555, 2'b00);   // R4 no lanes written
    do_op(0, 16, 0, 2'b11);
    do_op(1, 17'h1FFFF, 16'hBEEF, 2'b11);
    do_op(1, 0, 16'h0F0F, 2'b11);    // R7/R8 write after write
    do_op(0, 17'h1FFFF, 0, 2'b11);
    do_op(0, 17'h1FFFF, 0, 2'b11);   // same address twice
    do_op(0, 0, 0, 2'b11);
    for (int i = 0; i < 6; i++) begin
      do_op(1, i * 17'h1111, 16'(i * 16'h3C21 + 7), (i % 3 == 0) ? 2'b10 : 2'b11);
      do_op(0, i * 17'h1111, 0, 2'b11);
    end

    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "reads left unanswered", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule